// File: doc/BRIEF.md
# Frame Sync Ratio Monitor

This block decides whether a frame-sync pulse train can be trusted as a phase anchor. A downstream clock-recovery loop uses the result. Everything runs on a free-running master clock. The sync input and its companion reference clock are each brought into that domain through a short flop chain, and their rising edges are detected there. The master clock is 20 MHz by default.

Each synchronized sync edge closes one frame and opens the next. A closed frame is judged on two things:

- **Length:** the frame length, counted in master clocks, must lie inside a tolerance window around the nominal 8 kHz period.
- **Edge count:** the number of reference-clock rising edges inside the frame must equal a ratio given on a configuration input. The ratio is 256 for a 2.048 MHz reference and 193 for a 1.544 MHz reference.

If the sync pulse goes missing for too long, that also counts as a failure.

The monitor reports the sync as valid only after a run of consecutive good frames. A single bad frame or a timeout withdraws validity at once. While the failure flag is high, the downstream loop drops frame alignment and tracks the reference clock alone. The sync and reference inputs are sampled levels, and the flags are plain status levels. No data stream flows through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `fsync_ratio_mon`

## Requirements
- R1: After reset, and until qualification completes, sync_valid is 0 and sync_fail is 1. In every cycle, sync_fail is the inverse of sync_valid.
- R2: The length of a frame is the number of master clocks between two consecutive synchronized sync rising edges. It passes the length test when it lies in the inclusive window NOM_PERIOD-PERIOD_TOL to NOM_PERIOD+PERIOD_TOL. Any other length makes the frame bad.
- R3: The edge count of a frame is the number of synchronized reference rising edges inside it. It must equal exp_ratio, read as an unsigned number. A reference edge in the same master cycle as a sync edge belongs to the frame that this sync edge opens.
- R4: The first sync edge after reset or after a timeout only opens a measurement and produces no verdict. sync_valid rises in the cycle after the GOOD_FRAMES-th consecutive good frame is judged.
- R5: A bad frame clears sync_valid, and sets sync_fail, in the cycle after it is judged. The count of consecutive good frames restarts from zero.
- R6: A timeout occurs when TIMEOUT master clocks pass after the last sync edge with no new sync edge. The timeout is treated as a bad frame, and measurement is disarmed until the next sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Companion reference clock, sampled as a level |
| sync_in | input | 1 | Frame-sync pulse, sampled as a level |
| exp_ratio | input | RATIO_W | Expected number of reference rising edges per frame |
| sync_valid | output | 1 | Sync qualified for frame alignment |
| sync_fail | output | 1 | Sync failed; the loop tracks the reference clock only |

## Verification
The bench uses these parameter values:

| Parameter | Value |
|---|---|
| NOM_PERIOD | 100 |
| PERIOD_TOL | 4 |
| TIMEOUT | 130 |
| GOOD_FRAMES | 2 |
| RATIO_W | 8 |

The reference clock toggles every master clock, so a frame of P clocks holds exactly P/2 reference edges. With these values, frames of 94, 96, 104 and 106 clocks land on both sides of both window edges within a few hundred cycles. Ratios of one above and one below the true count are both tried. A silent gap of 140 clocks reaches the timeout while a gap of 120 clocks does not, and the re-arming after the timeout is checked.

// File: rtl/fsrm_pkg.sv
package fsrm_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_GOOD = 2'd1,
    VERD_BAD  = 2'd2
  } verdict_t;

  localparam int unsigned CHANNELS = 2;
  localparam int unsigned CH_REF   = 0;
  localparam int unsigned CH_SYNC  = 1;
endpackage

// File: rtl/fsrm_edge_sync.sv
module fsrm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      last <= 1'b0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      last <= pipe[STAGES-1];
    end
  end

  assign rise = pipe[STAGES-1] & ~last;

  // R3: a detected rising edge lasts one cycle only
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fsrm_period_meter.sv
module fsrm_period_meter #(
  parameter int unsigned NOM_PERIOD = 2500,
  parameter int unsigned PERIOD_TOL = 25,
  parameter int unsigned TIMEOUT    = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  output logic closed,
  output logic period_ok,
  output logic timeout
);
  localparam int unsigned W = $clog2(TIMEOUT + 1);
  localparam logic [W-1:0] LO_V = W'(NOM_PERIOD - PERIOD_TOL);
  localparam logic [W-1:0] HI_V = W'(NOM_PERIOD + PERIOD_TOL);
  localparam logic [W-1:0] TO_V = W'(TIMEOUT);

  logic [W-1:0] span;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span  <= '0;
      armed <= 1'b0;
    end else if (sof) begin
      span  <= W'(1);
      armed <= 1'b1;
    end else if (armed) begin
      if (span >= TO_V) begin
        span  <= '0;
        armed <= 1'b0;
      end else begin
        span <= span + W'(1);
      end
    end
  end

  assign closed    = sof & armed;
  assign period_ok = (span >= LO_V) && (span <= HI_V);
  assign timeout   = armed & ~sof & (span >= TO_V);

  // R6: a timeout disarms the measurement
  a_r6_timeout_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !armed);
  // R2: the span never runs past the timeout limit
  a_r2_span_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> span <= TO_V);
endmodule

// File: rtl/fsrm_edge_tally.sv
module fsrm_edge_tally #(
  parameter int unsigned RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  input  logic               ref_rise,
  input  logic [RATIO_W-1:0] exp_ratio,
  output logic               ratio_ok
);
  logic [RATIO_W-1:0] tally;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally <= '0;
    end else if (sof) begin
      tally <= ref_rise ? RATIO_W'(1) : '0;
    end else if (ref_rise && !(&tally)) begin
      tally <= tally + RATIO_W'(1);
    end
  end

  assign ratio_ok = (tally == exp_ratio);

  // R3: within a frame the tally never goes backwards
  a_r3_tally_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> tally >= $past(tally));
endmodule

// File: rtl/fsrm_qualifier.sv
module fsrm_qualifier
  import fsrm_pkg::*;
#(
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_t verdict,
  output logic     valid
);
  localparam int unsigned GW = $clog2(GOOD_FRAMES + 1);
  localparam logic [GW-1:0] NEED_V = GW'(GOOD_FRAMES);
  localparam logic [GW-1:0] LAST_V = GW'(GOOD_FRAMES - 1);

  logic [GW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      valid   <= 1'b0;
    end else begin
      case (verdict)
        VERD_GOOD: begin
          if (run_len != NEED_V) run_len <= run_len + GW'(1);
          if (run_len >= LAST_V) valid <= 1'b1;
        end
        VERD_BAD: begin
          run_len <= '0;
          valid   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R5: a bad frame withdraws validity on the next cycle
  a_r5_bad_drops: assert property (@(posedge clk) disable iff (!rst_n)
    verdict == VERD_BAD |=> !valid);
  // R4: validity only rises right after a good verdict
  a_r4_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(verdict == VERD_GOOD));
endmodule

// File: rtl/fsync_ratio_mon.sv
module fsync_ratio_mon
  import fsrm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NOM_PERIOD  = 2500,
  parameter int unsigned PERIOD_TOL  = 25,
  parameter int unsigned TIMEOUT     = 3000,
  parameter int unsigned RATIO_W     = 10,
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_in,
  input  logic               sync_in,
  input  logic [RATIO_W-1:0] exp_ratio,
  output logic               sync_valid,
  output logic               sync_fail
);
  logic [CHANNELS-1:0] raw;
  logic [CHANNELS-1:0] rises;
  logic                closed, period_ok, timeout, ratio_ok;
  verdict_t            verdict;

  assign raw[CH_REF]  = ref_clk_in;
  assign raw[CH_SYNC] = sync_in;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_in
    fsrm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .rise(rises[g])
    );
  end

  fsrm_period_meter #(
    .NOM_PERIOD(NOM_PERIOD), .PERIOD_TOL(PERIOD_TOL), .TIMEOUT(TIMEOUT)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .sof(rises[CH_SYNC]),
    .closed(closed), .period_ok(period_ok), .timeout(timeout)
  );

  fsrm_edge_tally #(.RATIO_W(RATIO_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .sof(rises[CH_SYNC]),
    .ref_rise(rises[CH_REF]), .exp_ratio(exp_ratio), .ratio_ok(ratio_ok)
  );

  always_comb begin
    verdict = VERD_NONE;
    if (closed)       verdict = (period_ok && ratio_ok) ? VERD_GOOD : VERD_BAD;
    else if (timeout) verdict = VERD_BAD;
  end

  fsrm_qualifier #(.GOOD_FRAMES(GOOD_FRAMES)) u_qual (
    .clk(clk), .rst_n(rst_n), .verdict(verdict), .valid(sync_valid)
  );

  assign sync_fail = ~sync_valid;

  // R6: a timeout leaves the sync failed on the next cycle
  a_r6_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> sync_fail);
endmodule

// File: tb/fsync_ratio_mon_test.sv
module fsync_ratio_mon_test;
  localparam int N_ST = 2;
  localparam int NOM = 100, TOL = 4, TMO = 130, GOODN = 2;

  logic clk = 0, rst_n = 0, ref_clk = 0, sync_in = 0;
  logic [7:0] exp_ratio = 8'd50;
  logic sync_valid, sync_fail;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fsync_ratio_mon #(
    .SYNC_STAGES(N_ST), .NOM_PERIOD(NOM), .PERIOD_TOL(TOL),
    .TIMEOUT(TMO), .RATIO_W(8), .GOOD_FRAMES(GOODN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk), .sync_in(sync_in),
    .exp_ratio(exp_ratio), .sync_valid(sync_valid), .sync_fail(sync_fail)
  );

  // behavioural reference model, one step per master clock
  bit hist[$];
  int m_span, m_tally, m_run;
  bit m_armed, m_valid, m_sprev, m_rprev;

  always @(posedge clk) begin
    bit sof, rr;
    if (!rst_n) begin
      m_span = 0; m_tally = 0; m_run = 0;
      m_armed = 0; m_valid = 0; m_sprev = 0; m_rprev = 0;
    end else begin
      sof = sync_in && !m_sprev;
      rr  = ref_clk && !m_rprev;
      m_sprev = sync_in; m_rprev = ref_clk;
      if (sof && m_armed) begin
        if (m_span >= NOM-TOL && m_span <= NOM+TOL && m_tally == int'(exp_ratio)) begin
          m_run++;
          if (m_run >= GOODN) m_valid = 1;
        end else begin
          m_run = 0; m_valid = 0;
        end
      end else if (!sof && m_armed && m_span >= TMO) begin
        m_run = 0; m_valid = 0;
      end
      if (sof) begin
        m_armed = 1; m_span = 1; m_tally = rr ? 1 : 0;
      end else begin
        if (m_armed) begin
          if (m_span >= TMO) begin m_armed = 0; m_span = 0; end
          else m_span++;
        end
        if (rr && m_tally < 255) m_tally++;
      end
    end
    hist.push_back(m_valid);
  end

  task automatic chk(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e;
    if (!done) begin
      e = (hist.size() > N_ST) ? hist[hist.size()-1-N_ST] : 1'b0;
      chk("R5 model valid", sync_valid, e);
      chk("R1 model fail", sync_fail, !e);
    end
  end

  initial begin
    forever begin @(posedge clk); #1; ref_clk = ~ref_clk; end
  end

  task automatic frames(int p, int n);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < p; i++) begin
        @(posedge clk); #1; sync_in = (i < 2);
      end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; sync_in = 0; end
  endtask

  task automatic probe(string tag, logic ev);
    @(negedge clk);
    chk(tag, sync_valid, ev);
    chk(tag, sync_fail, !ev);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    probe("R1 reset state", 0);
    frames(100, 2);
    probe("R4 one good frame not enough", 0);
    frames(100, 1);
    probe("R4 valid after two good frames", 1);
    exp_ratio = 8'd49; frames(100, 1);
    probe("R3 ratio one low", 0);
    exp_ratio = 8'd50; frames(100, 2);
    probe("R5 recovery after bad frame", 1);
    exp_ratio = 8'd51; frames(100, 1);
    probe("R3 ratio one high", 0);
    exp_ratio = 8'd48; frames(96, 3);
    probe("R2 lower window edge passes", 1);
    exp_ratio = 8'd52; frames(104, 3);
    probe("R2 upper window edge passes", 1);
    exp_ratio = 8'd47; frames(94, 3);
    probe("R2 short frame fails", 0);
    exp_ratio = 8'd53; frames(106, 3);
    probe("R2 long frame fails", 0);
    exp_ratio = 8'd50; frames(100, 3);
    probe("R5 valid again", 1);
    idle(20);
    probe("R6 gap below timeout keeps valid", 1);
    idle(20);
    probe("R6 gap past timeout fails", 0);
    frames(100, 2);
    probe("R6 first edge after timeout only arms", 0);
    frames(100, 1);
    probe("R4 requalified after timeout", 1);
    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule